// File: doc/BRIEF.md
# Manufacturing Test Tree Controller

This block sits beside the pad ring and decides, from a three-bit mode bus and three test-enable pins, whether the chip runs in one of its two normal system modes or in a manufacturing tree test. In a tree test it folds the outputs of all peripheral input buffers into one value: an AND chain closed by a final inversion (a NAND tree) or a successive XNOR fold. That value drives the dedicated test output. A tester can then prove that every input buffer works by toggling one pad at a time and watching that single output.

During a tree test the block also overrides the per-pin output enables. Every ordinary output or bidirectional pad goes to high impedance. A fixed exempt set, such as the interrupt pin, keeps its functional enable. Any code that is neither a normal mode nor one of the two test codes raises a reserved flag. It then behaves like normal operation with the test output held low. The whole block is combinational, so every output follows the pins in the same cycle.

Top module: `mfg_tree_ctrl`

## Requirements
- R1: With mode_sel_i = 3'b111 and {tck_i, ti_i, texec_i} = 3'b001, nand_mode_o is 1 and all other mode flags are 0.
- R2: With mode_sel_i = 3'b111 and {tck_i, ti_i, texec_i} = 3'b010, xnor_mode_o is 1 and all other mode flags are 0.
- R3: mode_sel_i = 3'b001 raises rmii_mode_o and mode_sel_i = 3'b010 raises smii_mode_o, whatever the test-enable pins hold; in both, oe_o equals func_oe_i and tout_o is 0.
- R4: Every other combination raises reserved_o, holds tout_o at 0 and passes func_oe_i unchanged to oe_o.
- R5: In either tree mode, oe_o bit i is 0 for every bit clear in EXEMPT_MASK, and equals func_oe_i bit i for every bit set in EXEMPT_MASK (default: bit N_OE-1 only).
- R6: In NAND mode, tout_o is the inverse of the AND of all ibuf_i bits: 0 with all inputs at 1, and 1 when any single input is 0.
- R7: In XNOR mode, tout_o is ibuf_i[0] folded through successive XNOR with ibuf_i[1] to ibuf_i[N_IN-1] (for even N_IN: the inverted parity), so flipping any one input flips tout_o.
- R8: Exactly one of rmii_mode_o, smii_mode_o, nand_mode_o, xnor_mode_o, reserved_o is 1 at all times.
- R9: All outputs follow input changes with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_sel_i | input | 3 | Mode-select pin bus |
| tck_i | input | 1 | Test enable pin, must be 0 for a tree test |
| ti_i | input | 1 | Test enable pin selecting the XNOR tree |
| texec_i | input | 1 | Test enable pin selecting the NAND tree |
| ibuf_i | input | N_IN | Outputs of the peripheral input buffers |
| func_oe_i | input | N_OE | Functional output enables from the core |
| oe_o | output | N_OE | Output enables driven to the pads |
| tout_o | output | 1 | Tree result to the test output pad |
| rmii_mode_o | output | 1 | Normal mode, first interface variant |
| smii_mode_o | output | 1 | Normal mode, second interface variant |
| nand_mode_o | output | 1 | NAND tree test active |
| xnor_mode_o | output | 1 | XNOR tree test active |
| reserved_o | output | 1 | Reserved pin combination present |

## Verification
The bench targets the near-miss codes: mode 111 with the test pins at 000, 011 or 101, and other mode values carrying valid test pins. A decoder that checked only part of the code would enter a test there, tri-state the pads and drive the test output. It toggles each input alone against an all-ones background in NAND mode. A plain NAND chain of alternating stages would miss inputs whose preceding stage sits at 0. It flips each input alone in XNOR mode, where a wrong fold would leave some pads unobservable. It also checks that the exempt pin keeps its enable during a test, which a blanket tri-state would break.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  localparam logic [2:0] MSEL_RMII = 3'b001;
  localparam logic [2:0] MSEL_SMII = 3'b010;
  localparam logic [2:0] MSEL_TEST = 3'b111;
  // {tck, ti, texec}
  localparam logic [2:0] TPIN_NAND = 3'b001;
  localparam logic [2:0] TPIN_XNOR = 3'b010;

  typedef enum logic [2:0] {
    M_RSV  = 3'd0,
    M_RMII = 3'd1,
    M_SMII = 3'd2,
    M_NAND = 3'd3,
    M_XNOR = 3'd4
  } mode_e;

  typedef enum logic {
    TREE_NAND = 1'b0,
    TREE_XNOR = 1'b1
  } tree_kind_e;
endpackage

// File: rtl/mtt_mode_decode.sv
module mtt_mode_decode
  import mtt_pkg::*;
(
  input  logic [2:0] mode_sel_i,
  input  logic       tck_i,
  input  logic       ti_i,
  input  logic       texec_i,
  output mode_e      mode_o
);
  logic [2:0] tpin;
  assign tpin = {tck_i, ti_i, texec_i};

  always_comb begin
    mode_o = M_RSV;
    unique case (mode_sel_i)
      MSEL_RMII: mode_o = M_RMII;
      MSEL_SMII: mode_o = M_SMII;
      MSEL_TEST: begin
        if (tpin == TPIN_NAND)      mode_o = M_NAND;
        else if (tpin == TPIN_XNOR) mode_o = M_XNOR;
        else                        mode_o = M_RSV;
      end
      default:   mode_o = M_RSV;
    endcase
  end
endmodule

// File: rtl/mtt_tree.sv
module mtt_tree
  import mtt_pkg::*;
#(
  parameter int unsigned N_IN = 8,
  parameter tree_kind_e  KIND = TREE_NAND
) (
  input  logic [N_IN-1:0] in_i,
  output logic            out_o
);
  if (KIND == TREE_NAND) begin : g_nand
    // AND carry along the chain, single inversion at the end keeps every
    // stage transparent while the others sit at 1
    logic [N_IN:0] carry;
    assign carry[0] = 1'b1;
    for (genvar k = 0; k < N_IN; k++) begin : g_stage
      assign carry[k+1] = carry[k] & in_i[k];
    end
    assign out_o = ~carry[N_IN];
  end else begin : g_xnor
    logic [N_IN-1:0] fold;
    assign fold[0] = in_i[0];
    for (genvar k = 1; k < N_IN; k++) begin : g_stage
      assign fold[k] = ~(fold[k-1] ^ in_i[k]);
    end
    assign out_o = fold[N_IN-1];
  end
endmodule

// File: rtl/mtt_oe_gen.sv
module mtt_oe_gen #(
  parameter int unsigned           N_OE        = 6,
  parameter logic [N_OE-1:0]       EXEMPT_MASK = {1'b1, {(N_OE-1){1'b0}}}
) (
  input  logic            test_i,
  input  logic [N_OE-1:0] func_oe_i,
  output logic [N_OE-1:0] oe_o
);
  for (genvar i = 0; i < N_OE; i++) begin : g_pin
    if (EXEMPT_MASK[i]) begin : g_keep
      assign oe_o[i] = func_oe_i[i];
    end else begin : g_hiz
      assign oe_o[i] = func_oe_i[i] & ~test_i;
    end
  end
endmodule

// File: rtl/mfg_tree_ctrl.sv
module mfg_tree_ctrl
  import mtt_pkg::*;
#(
  parameter int unsigned     N_IN        = 8,
  parameter int unsigned     N_OE        = 6,
  parameter logic [N_OE-1:0] EXEMPT_MASK = {1'b1, {(N_OE-1){1'b0}}}
) (
  input  logic [2:0]      mode_sel_i,
  input  logic            tck_i,
  input  logic            ti_i,
  input  logic            texec_i,
  input  logic [N_IN-1:0] ibuf_i,
  input  logic [N_OE-1:0] func_oe_i,
  output logic [N_OE-1:0] oe_o,
  output logic            tout_o,
  output logic            rmii_mode_o,
  output logic            smii_mode_o,
  output logic            nand_mode_o,
  output logic            xnor_mode_o,
  output logic            reserved_o
);
  mode_e mode;
  logic  nand_res, xnor_res, test_act;

  mtt_mode_decode u_dec (
    .mode_sel_i (mode_sel_i),
    .tck_i      (tck_i),
    .ti_i       (ti_i),
    .texec_i    (texec_i),
    .mode_o     (mode)
  );

  mtt_tree #(.N_IN(N_IN), .KIND(TREE_NAND)) u_nand (
    .in_i  (ibuf_i),
    .out_o (nand_res)
  );

  mtt_tree #(.N_IN(N_IN), .KIND(TREE_XNOR)) u_xnor (
    .in_i  (ibuf_i),
    .out_o (xnor_res)
  );

  assign rmii_mode_o = (mode == M_RMII);
  assign smii_mode_o = (mode == M_SMII);
  assign nand_mode_o = (mode == M_NAND);
  assign xnor_mode_o = (mode == M_XNOR);
  assign reserved_o  = (mode == M_RSV);
  assign test_act    = nand_mode_o | xnor_mode_o;

  always_comb begin
    tout_o = 1'b0;
    if (nand_mode_o)      tout_o = nand_res;
    else if (xnor_mode_o) tout_o = xnor_res;
  end

  mtt_oe_gen #(.N_OE(N_OE), .EXEMPT_MASK(EXEMPT_MASK)) u_oe (
    .test_i    (test_act),
    .func_oe_i (func_oe_i),
    .oe_o      (oe_o)
  );
endmodule

// File: rtl/mfg_tree_ctrl_chk.sv
module mfg_tree_ctrl_chk #(
  parameter int unsigned     N_OE        = 6,
  parameter logic [N_OE-1:0] EXEMPT_MASK = {1'b1, {(N_OE-1){1'b0}}}
) (
  input logic [2:0]      mode_sel_i,
  input logic            tck_i,
  input logic            ti_i,
  input logic            texec_i,
  input logic [N_OE-1:0] func_oe_i,
  input logic [N_OE-1:0] oe_o,
  input logic            tout_o,
  input logic            rmii_mode_o,
  input logic            smii_mode_o,
  input logic            nand_mode_o,
  input logic            xnor_mode_o,
  input logic            reserved_o
);
  always_comb begin
    // R8
    one_mode_chk: assert ($onehot({rmii_mode_o, smii_mode_o, nand_mode_o,
                                   xnor_mode_o, reserved_o}))
      else $error("mode flags not one-hot");
    // R1
    nand_code_chk: assert (!nand_mode_o ||
                           ({mode_sel_i, tck_i, ti_i, texec_i} == 6'b111_001))
      else $error("nand mode on wrong code");
    // R2
    xnor_code_chk: assert (!xnor_mode_o ||
                           ({mode_sel_i, tck_i, ti_i, texec_i} == 6'b111_010))
      else $error("xnor mode on wrong code");
    // R5
    test_hiz_chk: assert (!(nand_mode_o || xnor_mode_o) ||
                          ((oe_o & ~EXEMPT_MASK) == '0 &&
                           (oe_o & EXEMPT_MASK) == (func_oe_i & EXEMPT_MASK)))
      else $error("pads not tri-stated in test");
    // R4
    reserved_quiet_chk: assert (!reserved_o || (!tout_o && oe_o == func_oe_i))
      else $error("reserved code leaked test behaviour");
    // R3
    normal_pass_chk: assert (!(rmii_mode_o || smii_mode_o) ||
                             (!tout_o && oe_o == func_oe_i))
      else $error("normal mode altered pads");
  end
endmodule

bind mfg_tree_ctrl mfg_tree_ctrl_chk #(
  .N_OE        (N_OE),
  .EXEMPT_MASK (EXEMPT_MASK)
) u_chk (
  .mode_sel_i  (mode_sel_i),
  .tck_i       (tck_i),
  .ti_i        (ti_i),
  .texec_i     (texec_i),
  .func_oe_i   (func_oe_i),
  .oe_o        (oe_o),
  .tout_o      (tout_o),
  .rmii_mode_o (rmii_mode_o),
  .smii_mode_o (smii_mode_o),
  .nand_mode_o (nand_mode_o),
  .xnor_mode_o (xnor_mode_o),
  .reserved_o  (reserved_o)
);

// File: tb/mfg_tree_ctrl_bench.sv
module mfg_tree_ctrl_bench;
  localparam int N_IN = 8;
  localparam int N_OE = 6;
  localparam logic [N_OE-1:0] EXM = 6'b100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]      mode_sel;
  logic            tck, ti, texec;
  logic [N_IN-1:0] ibuf;
  logic [N_OE-1:0] func_oe, oe;
  logic            tout, f_rmii, f_smii, f_nand, f_xnor, f_rsv;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  mfg_tree_ctrl #(.N_IN(N_IN), .N_OE(N_OE), .EXEMPT_MASK(EXM)) u_mfg_tree_ctrl (
    .mode_sel_i  (mode_sel),
    .tck_i       (tck),
    .ti_i        (ti),
    .texec_i     (texec),
    .ibuf_i      (ibuf),
    .func_oe_i   (func_oe),
    .oe_o        (oe),
    .tout_o      (tout),
    .rmii_mode_o (f_rmii),
    .smii_mode_o (f_smii),
    .nand_mode_o (f_nand),
    .xnor_mode_o (f_xnor),
    .reserved_o  (f_rsv)
  );

  // {mode3, tck, ti, texec, ibuf8, func_oe6, exp_tout, exp_oe6, exp_flags5}
  // flags = {rmii, smii, nand, xnor, reserved}
  localparam int NV = 16;
  localparam logic [31:0] VEC [0:NV-1] = '{
    {3'b001, 3'b000, 8'hFF, 6'h3F, 1'b0, 6'h3F, 5'b10000},  // R3
    {3'b001, 3'b111, 8'h00, 6'h15, 1'b0, 6'h15, 5'b10000},  // R3
    {3'b010, 3'b010, 8'hFF, 6'h2A, 1'b0, 6'h2A, 5'b01000},  // R3
    {3'b111, 3'b001, 8'hFF, 6'h3F, 1'b0, 6'h20, 5'b00100},  // R1 R6
    {3'b111, 3'b001, 8'hFE, 6'h1F, 1'b1, 6'h00, 5'b00100},  // R1 R6
    {3'b111, 3'b001, 8'h7F, 6'h3F, 1'b1, 6'h20, 5'b00100},  // R6
    {3'b111, 3'b001, 8'h00, 6'h3F, 1'b1, 6'h20, 5'b00100},  // R6
    {3'b111, 3'b010, 8'hFF, 6'h3F, 1'b1, 6'h20, 5'b00010},  // R2 R7
    {3'b111, 3'b010, 8'hFE, 6'h00, 1'b0, 6'h00, 5'b00010},  // R7
    {3'b111, 3'b010, 8'h00, 6'h21, 1'b1, 6'h20, 5'b00010},  // R5 R7
    {3'b111, 3'b000, 8'hFF, 6'h3F, 1'b0, 6'h3F, 5'b00001},  // R4
    {3'b111, 3'b011, 8'hFF, 6'h0C, 1'b0, 6'h0C, 5'b00001},  // R4
    {3'b111, 3'b101, 8'hFF, 6'h11, 1'b0, 6'h11, 5'b00001},  // R4
    {3'b000, 3'b001, 8'hFF, 6'h2B, 1'b0, 6'h2B, 5'b00001},  // R4
    {3'b110, 3'b010, 8'hFF, 6'h3F, 1'b0, 6'h3F, 5'b00001},  // R4
    {3'b011, 3'b001, 8'hFE, 6'h07, 1'b0, 6'h07, 5'b00001}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [2:0] tp,
                       input logic [N_IN-1:0] ib, input logic [N_OE-1:0] fo);
    @(negedge clk);
    mode_sel = m;
    {tck, ti, texec} = tp;
    ibuf = ib;
    func_oe = fo;
    #1;
  endtask

  function automatic logic [4:0] flags();
    return {f_rmii, f_smii, f_nand, f_xnor, f_rsv};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    mode_sel = 3'b001;
    {tck, ti, texec} = 3'b000;
    ibuf = '0;
    func_oe = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // reset state: default pins give first normal mode, quiet test output
    check("R3 reset flags", {27'd0, flags()}, 32'b10000);
    check("R3 reset tout", {31'd0, tout}, 32'd0);
    check("R3 reset oe", {26'd0, oe}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] e;
      e = VEC[v];
      drive(e[31:29], e[28:26], e[25:18], e[17:12]);
      check("R1/R2/R3/R4/R8 vec flags", {27'd0, flags()}, {27'd0, e[4:0]});
      check("R6/R7/R4 vec tout", {31'd0, tout}, {31'd0, e[11]});
      check("R5/R3/R4 vec oe", {26'd0, oe}, {26'd0, e[10:5]});
    end

    // R6: single low input against an all-ones background
    for (int k = 0; k < N_IN; k++) begin
      drive(3'b111, 3'b001, ~(8'd1 << k), 6'h3F);
      check("R6 nand single toggle", {31'd0, tout}, 32'd1);
    end
    // R7: single flip from all zeros and from all ones
    for (int k = 0; k < N_IN; k++) begin
      drive(3'b111, 3'b010, 8'd1 << k, 6'h00);
      check("R7 xnor flip from zeros", {31'd0, tout}, 32'd0);
      drive(3'b111, 3'b010, ~(8'd1 << k), 6'h00);
      check("R7 xnor flip from ones", {31'd0, tout}, 32'd0);
    end
    // R5: exempt pin keeps its own enable, including when it is low
    drive(3'b111, 3'b001, 8'hFF, 6'h1F);
    check("R5 exempt low", {26'd0, oe}, 32'd0);
    drive(3'b111, 3'b010, 8'hFF, 6'h3F);
    check("R5 exempt high", {26'd0, oe}, 32'h20);

    // R9: output changes with no clock edge between input steps
    @(negedge clk);
    mode_sel = 3'b111; {tck, ti, texec} = 3'b001; ibuf = 8'hFF; func_oe = 6'h3F;
    #0.5;
    check("R9 nand immediate", {31'd0, tout}, 32'd0);
    ibuf = 8'hEF;
    #0.5;
    check("R9 tree follows input", {31'd0, tout}, 32'd1);
    texec = 1'b0;
    #0.5;
    check("R9 decode follows pins", {27'd0, flags()}, 32'b00001);
    check("R4 reserved oe restored", {26'd0, oe}, 32'h3F);

    finish_run();
  end
endmodule